// File: doc/BRIEF.md
# Accumulator Logic and Shift Unit

This execution unit serves an 8-bit accumulator CPU. It handles the bitwise group and the arithmetic shift group of that CPU. It can AND accumulator A or accumulator B with an operand, AND the condition-code byte with an immediate mask, and clear bits of a memory byte under a mask. It can also shift A, B, a memory byte, or the 16-bit pair D = A:B one place arithmetically, either left or right. Opcode fetch, addressing and memory access are handled elsewhere. The unit receives an operation code, the operands, a mask and the current condition-code byte, and returns the result together with the updated flags.

Operation takes one cycle. A request is accepted when `in_valid` is high at a rising clock edge. The result and the new flags appear on the registered outputs after that edge. The outputs hold their values until the next accepted request.

Top module: `acc_logic_shift`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res` and `ccr_out` are all zero.
- R2: At every edge out of reset, `out_valid` takes the value that `in_valid` had at that edge. An edge with `in_valid` low leaves `res` and `ccr_out` unchanged.
- R3: Op 0 gives `res` = {8'h00, A & M}. Op 1 gives `res` = {8'h00, B & M}.
- R4: Op 2 sets `ccr_out` = `ccr_in` & `mask_in`, and `res` = {8'h00, that same value}. Any flag may be cleared by this op.
- R5: Op 3 (bit clear) gives `res` = {8'h00, M & ~mask}.
- R6: For ops 0, 1 and 3, the flags are set as follows. N is result bit 7. Z is 1 when the 8-bit result is zero. V is 0. C keeps its input value.
- R7: Ops 4, 5 and 6 shift A, B and M, respectively, one place left. Bit 0 is filled with 0, and C receives the old bit 7. The result is placed in `res[7:0]`, with `res[15:8]` = 0.
- R8: Ops 8, 9 and 10 shift A, B and M, respectively, one place right. Bit 7 is kept, and C receives the old bit 0.
- R9: Op 7 shifts {A,B} left one place as a 16-bit value. A[7] goes to C, B[7] goes to bit 8 of the result, and bit 0 is 0.
- R10: For all shift ops, N is the result MSB (bit 15 for op 7, bit 7 otherwise). Z is 1 when the whole result is zero. V = N XOR C.
- R11: The condition-code byte is laid out as S=bit7, X=bit6, H=bit5, I=bit4, N=bit3, Z=bit2, V=bit1, C=bit0. Every op except op 2 copies bits 7..4 from `ccr_in` unchanged.
- R12: Op codes 11 to 15 give `res` = 0 and `ccr_out` = `ccr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted at this edge |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| m_in | input | 8 | Memory operand |
| mask_in | input | 8 | Immediate or bit mask |
| ccr_in | input | 8 | Current condition-code byte |
| out_valid | output | 1 | Result registered this cycle |
| res | output | 16 | Result |
| ccr_out | output | 8 | Updated condition-code byte |

## Verification
The bench covers the cases where a slip in the flag rules would show.

- **Shift of 0x80.** A left shift of 0x80 must give a zero result with C set and V set. A unit that took V from the input instead would be wrong here.
- **Right shift of 0x81.** This must keep the sign bit and set C. A logical right shift would instead clear N.
- **Double shift carry chain.** The double shift must carry B[7] into A[0]. It must also report Z only when all 16 bits are zero, so 0x0080 must not read as zero.
- **AND of the condition codes with 0x00.** This must clear every flag, including S through I. A unit that copied those bits through would keep them.
- **Logic ops with C set.** The logic ops must leave C set when it was set on entry.
- **Idle edges.** Edges with no request must not disturb the held outputs.

// File: rtl/acc_logic_shift.sv
module acc_logic_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  m_in,
  input  logic [7:0]  mask_in,
  input  logic [7:0]  ccr_in,
  output logic        out_valid,
  output logic [15:0] res,
  output logic [7:0]  ccr_out
);
  logic [7:0]  src;
  logic [15:0] r_n;
  logic        n_f, z_f, v_f, c_f;
  logic [7:0]  f_n;

  assign src = (op[1:0] == 2'd0) ? a_in : (op[1:0] == 2'd1) ? b_in : m_in;

  always_comb begin
    r_n = 16'h0;
    c_f = ccr_in[0];
    case (op)
      4'd0:  r_n = {8'h0, a_in & m_in};
      4'd1:  r_n = {8'h0, b_in & m_in};
      4'd2:  r_n = {8'h0, ccr_in & mask_in};
      4'd3:  r_n = {8'h0, m_in & ~mask_in};
      4'd4, 4'd5, 4'd6: begin
        r_n = {8'h0, src[6:0], 1'b0};
        c_f = src[7];
      end
      4'd7: begin
        r_n = {a_in[6:0], b_in, 1'b0};
        c_f = a_in[7];
      end
      4'd8, 4'd9, 4'd10: begin
        r_n = {8'h0, src[7], src[7:1]};
        c_f = src[0];
      end
      default: r_n = 16'h0;
    endcase
  end

  assign n_f = (op == 4'd7) ? r_n[15] : r_n[7];
  assign z_f = (r_n == 16'h0);
  assign v_f = (op >= 4'd4) ? (n_f ^ c_f) : 1'b0;

  always_comb begin
    if (op == 4'd2)
      f_n = ccr_in & mask_in;
    else if (op <= 4'd10)
      f_n = {ccr_in[7:4], n_f, z_f, v_f, c_f};
    else
      f_n = ccr_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= 16'h0;
      ccr_out   <= 8'h0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res     <= r_n;
        ccr_out <= f_n;
      end
    end
  end
endmodule

// File: rtl/acc_logic_shift_chk.sv
module acc_logic_shift_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [7:0]  a_in,
  input logic [7:0]  b_in,
  input logic [7:0]  m_in,
  input logic [7:0]  mask_in,
  input logic [7:0]  ccr_in,
  input logic        out_valid,
  input logic [15:0] res,
  input logic [7:0]  ccr_out
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res) && $stable(ccr_out));

  // R11
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != 4'd2 |=> ccr_out[7:4] == $past(ccr_in[7:4]));

  // R6
  logic_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op <= 4'd1 || op == 4'd3) |=> !ccr_out[1] && ccr_out[0] == $past(ccr_in[0]));

  // R10
  shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op >= 4'd4 && op <= 4'd10 |=> ccr_out[1] == (ccr_out[3] ^ ccr_out[0]));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != 4'd2 && op <= 4'd10 |=> ccr_out[2] == (res == 16'h0));
endmodule

bind acc_logic_shift acc_logic_shift_chk u_chk (.*);

// File: tb/test_acc_logic_shift.sv
`timescale 1ns/100ps
module test_acc_logic_shift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [7:0]  a_in = 8'h0, b_in = 8'h0, m_in = 8'h0, mask_in = 8'h0, ccr_in = 8'h0;
  logic        out_valid;
  logic [15:0] res;
  logic [7:0]  ccr_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_logic_shift i_acc_logic_shift (.*);

  function automatic logic [23:0] model(input logic [3:0] o, input logic [7:0] a, b, m, k, f);
    logic [7:0] x;
    logic [15:0] r;
    logic c, n;
    x = (o == 4'd4 || o == 4'd8) ? a : (o == 4'd5 || o == 4'd9) ? b : m;
    if (o == 4'd2) return {f & k, 8'h0, f & k};
    if (o > 4'd10) return {f, 16'h0};
    if (o <= 4'd3) begin
      r = (o == 4'd0) ? {8'h0, a & m} : (o == 4'd1) ? {8'h0, b & m} : {8'h0, m & ~k};
      return {f[7:4], r[7], r == 16'h0, 1'b0, f[0], r};
    end
    if (o == 4'd7) begin
      r = {a, b} << 1; c = a[7]; n = r[15];
    end else if (o <= 4'd6) begin
      r = {8'h0, x << 1}; c = x[7]; n = r[7];
    end else begin
      r = {8'h0, x[7], x[7:1]}; c = x[0]; n = r[7];
    end
    return {f[7:4], n, r == 16'h0, n ^ c, c, r};
  endfunction

  function automatic string res_req(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7: return "R9";
      4'd8, 4'd9, 4'd10: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] a, b, m, k, f);
    logic [23:0] e;
    op = o; a_in = a; b_in = b; m_in = m; mask_in = k; ccr_in = f; in_valid = 1'b1;
    e = model(o, a, b, m, k, f);
    @(negedge clk);
    check("R2", {23'h0, out_valid}, 24'h1);
    check(res_req(o), {8'h0, res}, {8'h0, e[15:0]});
    if (o == 4'd2) check("R4", {16'h0, ccr_out}, {16'h0, e[23:16]});
    else if (o <= 4'd3) check("R6", {16'h0, ccr_out}, {16'h0, e[23:16]});
    else if (o <= 4'd10) check("R10", {16'h0, ccr_out}, {16'h0, e[23:16]});
    else check("R12", {16'h0, ccr_out}, {16'h0, e[23:16]});
    if (o != 4'd2) check("R11", {20'h0, ccr_out[7:4]}, {20'h0, f[7:4]});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] hr;
    logic [7:0] hc;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1", {out_valid, res, ccr_out[6:0]}, 24'h0);
    check("R1", {16'h0, ccr_out}, 24'h0);
    rst_n = 1'b1;
    run(4'd4, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R7", {8'h0, res, ccr_out}, {8'h0, 16'h0000, 8'h07});
    run(4'd8, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R8", {8'h0, res, ccr_out}, {8'h0, 16'h00C0, 8'h09});
    run(4'd7, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00);
    check("R9", {8'h0, res, ccr_out}, {8'h0, 16'h0100, 8'h00});
    run(4'd7, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R10", {16'h0, ccr_out}, {16'h0, 8'h07});
    run(4'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
    check("R4", {16'h0, ccr_out}, 24'h0);
    run(4'd0, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'hF3);
    run(4'd3, 8'h00, 8'h00, 8'hFF, 8'h7F, 8'h01);
    run(4'd13, 8'h12, 8'h34, 8'h56, 8'h78, 8'hA5);
    hr = res; hc = ccr_out;
    op = 4'd4; a_in = 8'h55; in_valid = 1'b0;
    @(negedge clk);
    check("R2", {23'h0, out_valid}, 24'h0);
    check("R2", {res, ccr_out}, {hr, hc});
    for (int i = 0; i < 400; i++)
      run(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, res, ccr_out[6:0]}, 24'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule